// File: doc/BRIEF.md
# Serial Flash Power-Mode Controller

This block is the command front end and power-state keeper of a serial memory slave. Its SPI pins are sampled with a fast system clock. It collects the instruction byte shifted in while chip select is low, and it decides whether the device is idle, busy with an internal write/program/erase cycle, or asleep in its lowest-current state. A `busy_i` input stands in for the internal cycle. The memory array and the analog side are not part of the block.

Two instructions are handled here. The sleep opcode 0xB9 puts the device into deep power-down. The wake opcode 0xAB brings it back and also returns an 8-bit signature. Every other opcode that arrives while the device is awake is passed on through a one-cycle forward strobe. While asleep, every opcode except the wake opcode is dropped. The entry delay and the wake recovery delay are parameters counted in system clocks.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: After reset `mode_o` reads 0 (standby), `miso_en_o` is 0 and `fwd_valid_o` is 0. A reset taken while asleep also returns the block to standby.
- R2: Opcode 0xB9, sent MSB first with chip select rising right after its eighth bit and with `busy_i` low, sets `mode_o` to 2 (deep power-down) after T_DP clocks. Until then `mode_o` stays 0.
- R3: Opcode 0xB9 with chip select rising after 7, 9 or 16 bits is discarded, and `mode_o` stays 0.
- R4: Opcode 0xB9 received while `busy_i` is high is discarded, and the block does not go to sleep after `busy_i` falls.
- R5: While asleep, opcodes other than 0xAB (including 0xB9, 0x06, 0x02 and 0xD8) produce no `fwd_valid_o` pulse and leave `mode_o` at 2.
- R6: Opcode 0xAB received while asleep keeps `mode_o` at 2 during a T_RES-clock recovery that starts at the rise of chip select. After that, `mode_o` returns to 0.
- R7: After opcode 0xAB and three dummy bytes, `miso_o` shifts out SIG_BYTE MSB first. Bits change on SCLK falling edges and are valid at the next rising edge. The byte repeats while chip select stays low.
- R8: `miso_en_o` is 0 while chip select is high and 1 while it is low.
- R9: While awake, a first byte other than 0xB9 or 0xAB pulses `fwd_valid_o` for one clock, with the opcode on `fwd_op_o`.
- R10: While awake and `busy_i` is high, `mode_o` reads 1 (active). Raising chip select does not change this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI serial clock |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI serial data in |
| busy_i | input | 1 | Internal write/program/erase cycle in progress |
| miso_o | output | 1 | SPI serial data out |
| miso_en_o | output | 1 | Output enable for miso (high impedance when 0) |
| mode_o | output | 2 | 0 standby, 1 active, 2 deep power-down |
| fwd_valid_o | output | 1 | Strobe for a forwarded opcode |
| fwd_op_o | output | 8 | Forwarded opcode |

## Verification
The assertions rely on the SPI pins moving slowly compared with the system clock. Each level of SCLK must be held for several system clocks, so that every edge is seen exactly once. MOSI and chip select must be settled before the SCLK edge that samples them. The bench drives every pin on the falling system clock edge and holds each SCLK half period for four system clocks. It also raises or drops chip select only while SCLK is low.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_ACTIVE  = 2'd1,
    MODE_DPD     = 2'd2
  } pwr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTER = 2'd1,
    ST_DPD   = 2'd2,
    ST_WAKE  = 2'd3
  } pwr_state_e;

  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;
endpackage

// File: rtl/flash_spi_rx.sv
module flash_spi_rx
  import flash_pwr_pkg::*;
#(
  parameter int DUMMY_BYTES = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  output logic       sclk_fall_o,
  output logic       cs_high_o,
  output logic       cs_rise_o,
  output logic       op_done_o,
  output logic [7:0] op_o,
  output logic       op_valid_o,
  output logic       exact_op_o,
  output logic       sig_go_o
);
  localparam int BCW = $clog2(DUMMY_BYTES + 2) + 1;
  localparam logic [BCW-1:0] BMAX = '1;

  logic sclk_q, sclk_d, cs_q, cs_d, mosi_q;
  logic [6:0] shreg;
  logic [2:0] bit_cnt;
  logic [BCW-1:0] byte_cnt;
  logic [7:0] op_q;
  logic op_v, op_done_q;
  logic sclk_rise;

  assign sclk_rise   = sclk_q & ~sclk_d;
  assign sclk_fall_o = ~sclk_q & sclk_d;
  assign cs_high_o   = cs_q;
  assign cs_rise_o   = cs_q & ~cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      sclk_d    <= 1'b0;
      cs_q      <= 1'b1;
      cs_d      <= 1'b1;
      mosi_q    <= 1'b0;
      shreg     <= '0;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      op_q      <= '0;
      op_v      <= 1'b0;
      op_done_q <= 1'b0;
    end else begin
      sclk_q    <= sclk_i;
      sclk_d    <= sclk_q;
      cs_q      <= cs_ni;
      cs_d      <= cs_q;
      mosi_q    <= mosi_i;
      op_done_q <= 1'b0;
      if (cs_q) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
        op_v     <= 1'b0;
      end else if (sclk_rise) begin
        shreg   <= {shreg[5:0], mosi_q};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (byte_cnt != BMAX) byte_cnt <= byte_cnt + 1'b1;
          if (byte_cnt == '0) begin
            op_q      <= {shreg, mosi_q};
            op_v      <= 1'b1;
            op_done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign op_done_o  = op_done_q;
  assign op_o       = op_q;
  assign op_valid_o = op_v;
  assign exact_op_o = (byte_cnt == BCW'(1)) && (bit_cnt == 3'd0);
  assign sig_go_o   = op_v && (op_q == OP_WAKE) && (byte_cnt > BCW'(DUMMY_BYTES));

  // R9: opcode strobe only follows a serial clock rise while selected
  assert_op_after_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_q |-> $past(sclk_rise) && !$past(cs_q));
endmodule

// File: rtl/flash_sig_tx.sv
module flash_sig_tx #(
  parameter logic [7:0] SIG_BYTE = 8'h13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_high_i,
  input  logic fall_i,
  input  logic go_i,
  output logic miso_o
);
  logic [2:0] idx;
  logic miso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx    <= '0;
      miso_q <= 1'b0;
    end else if (cs_high_i) begin
      idx    <= '0;
      miso_q <= 1'b0;
    end else if (fall_i && go_i) begin
      miso_q <= SIG_BYTE[3'd7 - idx];
      idx    <= idx + 3'd1;
    end
  end

  assign miso_o = miso_q;

  assert_miso_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_i && !cs_high_i) |=> $stable(miso_q));
endmodule

// File: rtl/flash_pwr_fsm.sv
module flash_pwr_fsm
  import flash_pwr_pkg::*;
#(
  parameter int T_DP  = 64,
  parameter int T_RES = 96
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       cs_rise_i,
  input  logic       exact_op_i,
  input  logic       op_valid_i,
  input  logic [7:0] op_i,
  output pwr_state_e state_o,
  output pwr_mode_e  mode_o
);
  localparam int TMAX = (T_DP > T_RES) ? T_DP : T_RES;
  localparam int CW   = $clog2(TMAX + 1);

  pwr_state_e state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (cs_rise_i && exact_op_i && op_valid_i && op_i == OP_SLEEP && !busy_i) begin
          state <= ST_ENTER;
          cnt   <= '0;
        end
        ST_ENTER: if (cnt == CW'(T_DP - 1)) state <= ST_DPD;
                  else cnt <= cnt + 1'b1;
        ST_DPD: if (cs_rise_i && op_valid_i && op_i == OP_WAKE) begin
          state <= ST_WAKE;
          cnt   <= '0;
        end
        ST_WAKE: if (cnt == CW'(T_RES - 1)) state <= ST_IDLE;
                 else cnt <= cnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (state == ST_DPD || state == ST_WAKE) mode_o = MODE_DPD;
    else if (busy_i)                         mode_o = MODE_ACTIVE;
    else                                     mode_o = MODE_STANDBY;
  end

  assign state_o = state;

  assert_dpd_via_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DPD && $past(state) != ST_DPD) |-> $past(state) == ST_ENTER);
  assert_entry_exact_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ENTER && $past(state) == ST_IDLE) |-> $past(exact_op_i));
  assert_entry_not_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ENTER && $past(state) == ST_IDLE) |-> !$past(busy_i));
  assert_wake_from_dpd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAKE && $past(state) != ST_WAKE) |-> $past(state) == ST_DPD);
endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
  import flash_pwr_pkg::*;
#(
  parameter int         T_DP        = 64,
  parameter int         T_RES       = 96,
  parameter int         DUMMY_BYTES = 3,
  parameter logic [7:0] SIG_BYTE    = 8'h13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  input  logic       busy_i,
  output logic       miso_o,
  output logic       miso_en_o,
  output logic [1:0] mode_o,
  output logic       fwd_valid_o,
  output logic [7:0] fwd_op_o
);
  logic sclk_fall, cs_high, cs_rise, op_done, op_valid, exact_op, sig_go;
  logic [7:0] op;
  pwr_state_e state;
  pwr_mode_e  mode;

  flash_spi_rx #(.DUMMY_BYTES(DUMMY_BYTES)) u_rx (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .sclk_fall_o(sclk_fall), .cs_high_o(cs_high), .cs_rise_o(cs_rise),
    .op_done_o(op_done), .op_o(op), .op_valid_o(op_valid),
    .exact_op_o(exact_op), .sig_go_o(sig_go)
  );

  flash_sig_tx #(.SIG_BYTE(SIG_BYTE)) u_tx (
    .clk_i, .rst_ni, .cs_high_i(cs_high), .fall_i(sclk_fall),
    .go_i(sig_go), .miso_o(miso_o)
  );

  flash_pwr_fsm #(.T_DP(T_DP), .T_RES(T_RES)) u_fsm (
    .clk_i, .rst_ni, .busy_i, .cs_rise_i(cs_rise), .exact_op_i(exact_op),
    .op_valid_i(op_valid), .op_i(op), .state_o(state), .mode_o(mode)
  );

  assign miso_en_o   = ~cs_high;
  assign mode_o      = mode;
  assign fwd_valid_o = op_done && state == ST_IDLE && op != OP_SLEEP && op != OP_WAKE;
  assign fwd_op_o    = op;

  assert_no_fwd_asleep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> mode_o != 2'd2);
  assert_fwd_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |=> !fwd_valid_o);
endmodule

// File: tb/flash_pwr_ctrl_test.sv
`timescale 1ns/1ps
module flash_pwr_ctrl_test;
  localparam int T_DP = 20;
  localparam int T_RES = 30;
  localparam int HALF = 4;
  localparam logic [7:0] SIG = 8'h13;
  // {opcode, bit count, busy, expected mode}
  localparam logic [15:0] VECS [7] = '{
    {8'hB9, 5'd8,  1'b0, 2'd2},
    {8'hB9, 5'd7,  1'b0, 2'd0},
    {8'hB9, 5'd9,  1'b0, 2'd0},
    {8'hB9, 5'd16, 1'b0, 2'd0},
    {8'hB9, 5'd8,  1'b1, 2'd0},
    {8'h06, 5'd8,  1'b0, 2'd0},
    {8'hD8, 5'd8,  1'b0, 2'd0}
  };

  logic clk = 0, rst_ni = 0, sclk = 0, cs_n = 1, mosi = 0, busy = 0;
  logic miso, miso_en, fwd_valid;
  logic [1:0] mode;
  logic [7:0] fwd_op, fwd_last;
  int tests = 0, fails = 0, fwd_cnt = 0;

  always #2.5 clk = ~clk;

  flash_pwr_ctrl #(.T_DP(T_DP), .T_RES(T_RES), .SIG_BYTE(SIG)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .busy_i(busy), .miso_o(miso), .miso_en_o(miso_en), .mode_o(mode),
    .fwd_valid_o(fwd_valid), .fwd_op_o(fwd_op)
  );

  always @(posedge clk) if (fwd_valid) begin
    fwd_cnt <= fwd_cnt + 1;
    fwd_last <= fwd_op;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nb; i++) begin
      mosi = tx[7 - (i % 8)];
      repeat (HALF) @(negedge clk);
      rx = {rx[6:0], miso};
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
  endtask

  task automatic cmd(input logic [7:0] op, input int nb);
    logic [7:0] d;
    @(negedge clk) cs_n = 0;
    repeat (2) @(negedge clk);
    xfer(op, nb, d);
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r1, r2;
    int f0;
    string tag;
    repeat (5) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(mode == 2'd0, "R1 mode", mode, 0);
    chk(miso_en == 1'b0, "R1/R8 miso_en", miso_en, 0);
    chk(fwd_valid == 1'b0, "R1 fwd", fwd_valid, 0);

    for (int k = 0; k < 7; k++) begin
      logic [7:0] op = VECS[k][15:8];
      int nb = int'(VECS[k][7:3]);
      logic bz = VECS[k][2];
      logic [1:0] ex = VECS[k][1:0];
      tag = (nb != 8) ? "R3" : bz ? "R4" : (op == 8'hB9) ? "R2" : "R9";
      f0 = fwd_cnt;
      busy = bz;
      cmd(op, nb);
      if (bz) begin
        chk(mode == 2'd1, "R10 active while busy", mode, 1);
        busy = 0;
      end else if (ex == 2'd2) begin
        chk(mode == 2'd0, "R2 standby during delay", mode, 0);
      end
      repeat (T_DP + 10) @(negedge clk);
      chk(mode == ex, tag, mode, ex);
      if (op != 8'hB9 && nb == 8) begin
        chk(fwd_cnt == f0 + 1 && fwd_last == op, "R9 forward", fwd_last, op);
      end else begin
        chk(fwd_cnt == f0, {tag, " no forward"}, fwd_cnt - f0, 0);
      end
      if (ex == 2'd2) begin
        cmd(8'hAB, 8);
        repeat (T_RES + 10) @(negedge clk);
        chk(mode == 2'd0, "R6 woken", mode, 0);
      end
    end

    // R5: asleep, other opcodes dropped
    cmd(8'hB9, 8);
    repeat (T_DP + 10) @(negedge clk);
    chk(mode == 2'd2, "R2 asleep", mode, 2);
    f0 = fwd_cnt;
    cmd(8'h06, 8);
    cmd(8'h02, 8);
    cmd(8'hD8, 8);
    cmd(8'hB9, 8);
    chk(fwd_cnt == f0, "R5 no forward asleep", fwd_cnt - f0, 0);
    chk(mode == 2'd2, "R5 still asleep", mode, 2);

    // R6: recovery window
    cmd(8'hAB, 8);
    chk(mode == 2'd2, "R6 during recovery", mode, 2);
    repeat (T_RES + 10) @(negedge clk);
    chk(mode == 2'd0, "R6 after recovery", mode, 0);

    // R7 / R8: signature readout
    @(negedge clk) cs_n = 0;
    repeat (2) @(negedge clk);
    chk(miso_en == 1'b1, "R8 enabled while selected", miso_en, 1);
    xfer(8'hAB, 8, r1);
    for (int j = 0; j < 3; j++) xfer(8'h00, 8, r1);
    xfer(8'h00, 8, r1);
    xfer(8'h00, 8, r2);
    chk(r1 == SIG, "R7 signature", r1, SIG);
    chk(r2 == SIG, "R7 signature repeat", r2, SIG);
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (4) @(negedge clk);
    chk(miso_en == 1'b0, "R8 disabled when deselected", miso_en, 0);

    // R10: chip select rise while busy
    busy = 1;
    cmd(8'h05, 8);
    chk(mode == 2'd1, "R10 busy after deselect", mode, 1);
    busy = 0;
    @(negedge clk);

    // R1: reset while asleep
    cmd(8'hB9, 8);
    repeat (T_DP + 10) @(negedge clk);
    chk(mode == 2'd2, "R2 asleep again", mode, 2);
    rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(mode == 2'd0, "R1 reset from sleep", mode, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule